// File: doc/BRIEF.md
# Multi-channel DAC serial command decoder

This block is the digital front end of a serially programmed multi-channel digital-to-analog converter. A host writes 24-bit command frames over a write-only SPI slave port (mode 0, most significant bit first). The port pins are synchronised into the system clock domain. A frame counts only when chip select rises after exactly 24 clock edges. Each accepted frame carries a command in bits 23:20, a channel address in bits 19:16 and a left-justified data code in bits 15:0.

Every channel has two register stages. The staging register receives codes. The active register drives the converter. Separate commands load the staging register, move it to the active register, or do both, for one channel, for every channel, or as a load of one channel followed by a move of all of them. Further commands put one channel or the whole device into power-down and choose the internal or external voltage reference. The channel count (2, 4 or 8) and the resolution (8, 10 or 12 bits) are parameters.

Top module: `dac_cmd_frontend`

## Requirements
- R1: After reset every staging and active code is zero, all channel power-down flags and the chip power-down flag are 0, and `ref_ext` is 0 (internal reference).
- R2: A frame is decoded only when `spi_cs_n` rises after exactly 24 rising edges of `spi_sclk` while it was low. A frame of any other length changes no output.
- R3: Command 0x0 stores the code in frame bits 15 down to 16-RES into the addressed channel's staging register. No output changes. The 16-RES lowest bits are ignored.
- R4: Command 0x1 copies the addressed channel's staging register to its active register. The data field is ignored.
- R5: Command 0x2 loads the addressed channel's staging register, then copies every channel's staging register to its active register.
- R6: Command 0x3 loads the addressed channel's staging register and its active register with the frame code. Other channels are unchanged.
- R7: Command 0x4 sets the addressed channel's power-down flag (bit n of `ch_pd` for channel n). Command 0x5 sets `chip_pd` whatever the address.
- R8: Commands 0x1, 0x2 and 0x3 clear the power-down flag of each channel whose active register they update, and they clear `chip_pd`.
- R9: Command 0x6 clears `ref_ext` and command 0x7 sets it, whatever the address.
- R10: Address 0xF applies commands 0x0 to 0x4 to every channel. For those commands, an address from NUM_CH to 0xE leaves every output unchanged.
- R11: Commands 0x8 to 0xF leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock; data sampled on its rising edge |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data, most significant bit first |
| dac_code | output | NUM_CH*RES | Active codes, channel n at bits n*RES +: RES |
| ch_pd | output | NUM_CH | Per-channel power-down flags |
| chip_pd | output | 1 | Whole-device power-down flag |
| ref_ext | output | 1 | 1 selects the external reference |

## Verification
The assertions assume that each serial clock level, and each chip-select level, lasts at least two system clocks. This lets the synchroniser see every edge. They also assume `spi_mosi` is stable across the sampling edge, and that chip select stays high for several system clocks between frames. The bench holds every serial clock phase for four system clocks, changes data only while the serial clock is low, and leaves chip select high for at least sixteen system clocks between frames.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
    localparam int FRAME_W = 24;
    localparam int CMD_LSB = 20;
    localparam int ADR_LSB = 16;
    localparam logic [3:0] ADDR_ALL = 4'hF;

    typedef enum logic [3:0] {
        OP_STAGE        = 4'h0,
        OP_COMMIT       = 4'h1,
        OP_STAGE_ALL    = 4'h2,
        OP_STAGE_COMMIT = 4'h3,
        OP_SLEEP_CH     = 4'h4,
        OP_SLEEP_CHIP   = 4'h5,
        OP_REF_INT      = 4'h6,
        OP_REF_EXT      = 4'h7
    } op_code_e;
endpackage

// File: rtl/dac_spi_rx.sv
module dac_spi_rx
    import dac_fe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    typedef struct packed {
        logic [2:0]         sclk_sy;
        logic [2:0]         cs_sy;
        logic [1:0]         mosi_sy;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               vld;
        logic [FRAME_W-1:0] word;
    } rx_t;

    rx_t rx_d, rx_q;

    logic sclk_rise, cs_rise, cs_low;

    always_comb begin
        rx_d = rx_q;
        rx_d.sclk_sy = {rx_q.sclk_sy[1:0], sclk};
        rx_d.cs_sy   = {rx_q.cs_sy[1:0], cs_n};
        rx_d.mosi_sy = {rx_q.mosi_sy[0], mosi};
        sclk_rise = rx_q.sclk_sy[1] & ~rx_q.sclk_sy[2];
        cs_rise   = rx_q.cs_sy[1] & ~rx_q.cs_sy[2];
        cs_low    = ~rx_q.cs_sy[1];
        rx_d.vld  = 1'b0;
        if (cs_rise) begin
            rx_d.vld = (rx_q.cnt == CNT_FULL);
            rx_d.word = rx_q.shreg;
            rx_d.cnt = '0;
        end else if (!cs_low) begin
            rx_d.cnt = '0;
        end else if (sclk_rise) begin
            rx_d.shreg = {rx_q.shreg[FRAME_W-2:0], rx_q.mosi_sy[1]};
            if (rx_q.cnt != CNT_MAX) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{sclk_sy: 3'b000, cs_sy: 3'b111, mosi_sy: 2'b00,
                      shreg: '0, cnt: '0, vld: 1'b0, word: '0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign frame_vld = rx_q.vld;
    assign frame     = rx_q.word;

    // R2: an accepted frame produces a single-cycle strobe
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_fe_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES    = 12
) (
    input  logic               frame_vld,
    input  logic [FRAME_W-1:0] frame,
    output logic [NUM_CH-1:0]  stage_mask,
    output logic [NUM_CH-1:0]  commit_mask,
    output logic [NUM_CH-1:0]  sleep_mask,
    output logic               chip_sleep,
    output logic               ref_wr,
    output logic               ref_val,
    output logic [RES-1:0]     code
);
    localparam logic [4:0] NCH5 = 5'(NUM_CH);

    logic [3:0]        cmd;
    logic [3:0]        adr;
    logic [NUM_CH-1:0] target;
    logic              adr_ok;
    logic              unused_low;

    assign cmd  = frame[CMD_LSB +: 4];
    assign adr  = frame[ADR_LSB +: 4];
    assign code = frame[ADR_LSB-1 -: RES];
    assign unused_low = ^frame[ADR_LSB-1-RES:0];
    assign adr_ok = (adr == ADDR_ALL) || ({1'b0, adr} < NCH5);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_tgt
        assign target[g] = (adr == ADDR_ALL) || (adr == 4'(g));
    end

    always_comb begin
        stage_mask  = '0;
        commit_mask = '0;
        sleep_mask  = '0;
        chip_sleep  = 1'b0;
        ref_wr      = 1'b0;
        ref_val     = 1'b0;
        if (frame_vld) begin
            case (cmd)
                OP_STAGE:        if (adr_ok) stage_mask = target;
                OP_COMMIT:       if (adr_ok) commit_mask = target;
                OP_STAGE_ALL:    if (adr_ok) begin
                                     stage_mask  = target;
                                     commit_mask = '1;
                                 end
                OP_STAGE_COMMIT: if (adr_ok) begin
                                     stage_mask  = target;
                                     commit_mask = target;
                                 end
                OP_SLEEP_CH:     if (adr_ok) sleep_mask = target;
                OP_SLEEP_CHIP:   chip_sleep = 1'b1;
                OP_REF_INT:      ref_wr = 1'b1;
                OP_REF_EXT:      begin
                                     ref_wr  = 1'b1;
                                     ref_val = 1'b1;
                                 end
                default:         ;
            endcase
        end
    end
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank #(
    parameter int NUM_CH = 8,
    parameter int RES    = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_vld,
    input  logic [NUM_CH-1:0]       stage_mask,
    input  logic [NUM_CH-1:0]       commit_mask,
    input  logic [NUM_CH-1:0]       sleep_mask,
    input  logic                    chip_sleep,
    input  logic                    ref_wr,
    input  logic                    ref_val,
    input  logic [RES-1:0]          code,
    output logic [NUM_CH*RES-1:0]   dac_code,
    output logic [NUM_CH-1:0]       ch_pd,
    output logic                    chip_pd,
    output logic                    ref_ext
);
    typedef struct packed {
        logic [NUM_CH-1:0][RES-1:0] stage;
        logic [NUM_CH-1:0][RES-1:0] active;
        logic [NUM_CH-1:0]          pd;
        logic                       chip_pd;
        logic                       ref_ext;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (stage_mask[i]) begin
                bk_d.stage[i] = code;
            end
            if (commit_mask[i]) begin
                bk_d.active[i] = bk_d.stage[i];
                bk_d.pd[i]     = 1'b0;
            end
            if (sleep_mask[i]) begin
                bk_d.pd[i] = 1'b1;
            end
        end
        if (|commit_mask) begin
            bk_d.chip_pd = 1'b0;
        end
        if (chip_sleep) begin
            bk_d.chip_pd = 1'b1;
        end
        if (ref_wr) begin
            bk_d.ref_ext = ref_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign dac_code = bk_q.active;
    assign ch_pd    = bk_q.pd;
    assign chip_pd  = bk_q.chip_pd;
    assign ref_ext  = bk_q.ref_ext;

    // R2: without an accepted frame no output moves
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> ($stable(dac_code) && $stable(ch_pd) &&
                        $stable(chip_pd) && $stable(ref_ext)));

    // R8: any update wakes the chip
    p_commit_wakes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit_mask) |=> !chip_pd);

    // R7: a channel sleep request shows on the flags
    p_sleep_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|sleep_mask) |=> ((ch_pd & $past(sleep_mask)) == $past(sleep_mask)));

    // R9: reference select follows the command
    p_ref_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_wr |=> (ref_ext == $past(ref_val)));

    // R6: channels outside the masks keep their active code
    p_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_mask == '0) |=> $stable(dac_code));
endmodule

// File: rtl/dac_cmd_frontend.sv
module dac_cmd_frontend
    import dac_fe_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic [NUM_CH*RES-1:0] dac_code,
    output logic [NUM_CH-1:0]     ch_pd,
    output logic                  chip_pd,
    output logic                  ref_ext
);
    initial begin
        a_params: assert ((NUM_CH == 2 || NUM_CH == 4 || NUM_CH == 8) &&
                          (RES == 8 || RES == 10 || RES == 12));
    end

    logic               frame_vld;
    logic [FRAME_W-1:0] frame;
    logic [NUM_CH-1:0]  stage_mask, commit_mask, sleep_mask;
    logic               chip_sleep, ref_wr, ref_val;
    logic [RES-1:0]     code;

    dac_spi_rx rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .frame_vld (frame_vld),
        .frame     (frame)
    );

    dac_cmd_decode #(.NUM_CH(NUM_CH), .RES(RES)) dec_i (
        .frame_vld   (frame_vld),
        .frame       (frame),
        .stage_mask  (stage_mask),
        .commit_mask (commit_mask),
        .sleep_mask  (sleep_mask),
        .chip_sleep  (chip_sleep),
        .ref_wr      (ref_wr),
        .ref_val     (ref_val),
        .code        (code)
    );

    dac_reg_bank #(.NUM_CH(NUM_CH), .RES(RES)) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_vld   (frame_vld),
        .stage_mask  (stage_mask),
        .commit_mask (commit_mask),
        .sleep_mask  (sleep_mask),
        .chip_sleep  (chip_sleep),
        .ref_wr      (ref_wr),
        .ref_val     (ref_val),
        .code        (code),
        .dac_code    (dac_code),
        .ch_pd       (ch_pd),
        .chip_pd     (chip_pd),
        .ref_ext     (ref_ext)
    );
endmodule

// File: tb/dac_cmd_frontend_tb.sv
`timescale 1ns/1ps
module dac_cmd_frontend_tb_top;
    localparam int NCH = 8;
    localparam int RW  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [NCH*RW-1:0] dac_code;
    logic [NCH-1:0]    ch_pd;
    logic              chip_pd, ref_ext;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dac_cmd_frontend #(.NUM_CH(NCH), .RES(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .dac_code(dac_code), .ch_pd(ch_pd),
        .chip_pd(chip_pd), .ref_ext(ref_ext)
    );

    typedef struct packed {
        logic [23:0] frame;
        logic [3:0]  ch;
        logic [11:0] dac;
        logic [7:0]  pd;
        logic        chip;
        logic        refx;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{24'h02ABC0, 4'd2, 12'h000, 8'h00, 1'b0, 1'b0}, // R3 stage only
        '{24'h120000, 4'd2, 12'hABC, 8'h00, 1'b0, 1'b0}, // R4 commit
        '{24'h351230, 4'd5, 12'h123, 8'h00, 1'b0, 1'b0}, // R6 stage+commit
        '{24'h015550, 4'd1, 12'h000, 8'h00, 1'b0, 1'b0}, // R3
        '{24'h207770, 4'd1, 12'h555, 8'h00, 1'b0, 1'b0}, // R5 commit all
        '{24'h430000, 4'd3, 12'h000, 8'h08, 1'b0, 1'b0}, // R7 channel sleep
        '{24'h500000, 4'd0, 12'h777, 8'h08, 1'b1, 1'b0}, // R7 chip sleep
        '{24'h130000, 4'd3, 12'h000, 8'h00, 1'b0, 1'b0}, // R8 wake
        '{24'h700000, 4'd0, 12'h777, 8'h00, 1'b0, 1'b1}, // R9 external
        '{24'h690000, 4'd0, 12'h777, 8'h00, 1'b0, 1'b0}, // R9 internal
        '{24'h0F3C30, 4'd0, 12'h777, 8'h00, 1'b0, 1'b0}, // R10 broadcast stage
        '{24'h1F0000, 4'd7, 12'h3C3, 8'h00, 1'b0, 1'b0}, // R10 broadcast commit
        '{24'h39FFF0, 4'd1, 12'h3C3, 8'h00, 1'b0, 1'b0}, // R10 bad address
        '{24'h480000, 4'd0, 12'h3C3, 8'h00, 1'b0, 1'b0}, // R10 bad address
        '{24'h4F0000, 4'd0, 12'h3C3, 8'hFF, 1'b0, 1'b0}, // R10 broadcast sleep
        '{24'h24ABC0, 4'd4, 12'hABC, 8'h00, 1'b0, 1'b0}, // R8 R5 wake all
        '{24'h901110, 4'd0, 12'h3C3, 8'h00, 1'b0, 1'b0}, // R11 unused cmd
        '{24'h36ABCF, 4'd6, 12'hABC, 8'h00, 1'b0, 1'b0}  // R3 low bits ignored
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] f, input int nbits);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? f[23-i] : 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(16);
    endtask

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] chan(input int c);
        return dac_code[c*RW +: RW];
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset state
        check("R1 dac", 32'(|dac_code), 0);
        check("R1 pd", 32'(ch_pd), 0);
        check("R1 chip_pd", 32'(chip_pd), 0);
        check("R1 ref_ext", 32'(ref_ext), 0);

        for (int v = 0; v < NV; v++) begin
            send(VEC[v].frame, 24);
            check($sformatf("vector %0d dac (R3-R11 table)", v),
                  32'(chan(int'(VEC[v].ch))), 32'(VEC[v].dac));
            check($sformatf("vector %0d ch_pd", v), 32'(ch_pd), 32'(VEC[v].pd));
            check($sformatf("vector %0d chip_pd", v), 32'(chip_pd), 32'(VEC[v].chip));
            check($sformatf("vector %0d ref_ext", v), 32'(ref_ext), 32'(VEC[v].refx));
        end
        // R5: all other channels were committed by the 0x2 frame
        check("R5 ch0", 32'(chan(0)), 32'h3C3);
        check("R5 ch7", 32'(chan(7)), 32'h3C3);

        // R2 short and long frames are discarded
        send(24'h301110, 23);
        check("R2 short frame ch0", 32'(chan(0)), 32'h3C3);
        send(24'h301110, 25);
        check("R2 long frame ch0", 32'(chan(0)), 32'h3C3);
        send(24'h400000, 23);
        check("R2 short frame pd", 32'(ch_pd), 0);
        send(24'h305A50, 24);
        check("R2 good frame after bad", 32'(chan(0)), 32'h5A5);

        // R11 top command code
        send(24'hF22220, 24);
        check("R11 cmd F ch2", 32'(chan(2)), 32'h3C3);

        // R1 reset again
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(2);
        check("R1 re-reset dac", 32'(|dac_code), 0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule